// File: doc/BRIEF.md
# Multi-Engine Reset Handshake Sequencer

This block guards the full reset of a device that holds several execution engines. An engine may only be reset once it reports that it is at a safe point: no context switch is in flight and its state has been saved. On a start pulse the sequencer visits the engines one after another over a simple register port. For each engine it sets a request bit in that engine's reset-control register, then reads the register until the engine's ready bit comes up or a cycle budget runs out.

When every engine has answered, the block emits a one-cycle global reset pulse. It then waits for the reset domain to acknowledge completion and reports done. If any engine fails to answer in time, the block withdraws the request from every engine, never issues the global reset, raises an error pulse and locks into a wedged state. It also errors and wedges if the completion acknowledge does not arrive within the budget. The wedged state is never left on its own. Only an explicit unwedge input or a power-on reset clears it.

Top module: `eng_rst_seq`

## Requirements
- R1: After reset, bus_vld_o, grst_o, done_o, err_o and wedged_o are all 0.
- R2: Engines are visited in index order 0..N_ENG-1. Each visit writes 0x0001_0001 to ENG_BASE[i]+0xD0. Bits 31:16 of a write are a write-enable mask for bits 15:0, and bit 0 is the request bit. The visit then reads only that same address until read bit 1 (ready) is 1, and only after that does the next engine's write appear.
- R3: grst_o is a single-cycle pulse. It is issued only after every engine has read back ready.
- R4: After grst_o, done_o pulses for one cycle once grst_done_i is seen, and the block returns to idle.
- R5: If an engine is still not ready at the first read that completes after TIMEOUT_CYC cycles of polling, the block writes 0x0001_0000 to the control register of every engine, in index order 0..N_ENG-1 and including engines never requested. It then pulses err_o and issues no grst_o.
- R6: After an error the block holds wedged_o=1 and ignores start_i, making no bus access. A unwedge_i pulse returns it to idle, and a later start runs normally.
- R7: A start_i pulse while a sequence is running has no effect: no extra bus writes appear and no second sequence follows.
- R8: If grst_done_i does not arrive within TIMEOUT_CYC cycles after grst_o, the block pulses err_o and becomes wedged.
- R9: An engine that becomes ready before the budget expires does not cause a timeout.
- R10: A bus request holds its address, data and direction stable until bus_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| start_i | input | 1 | Begin a reset handshake sequence (pulse) |
| unwedge_i | input | 1 | Clear the wedged state |
| bus_vld_o | output | 1 | Register access request |
| bus_wr_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | DATA_W | Masked write data |
| bus_ack_i | input | 1 | Access accepted; read data valid |
| bus_rdata_i | input | DATA_W | Read data |
| grst_o | output | 1 | Global reset pulse |
| grst_done_i | input | 1 | Global reset completion acknowledge |
| done_o | output | 1 | Sequence finished successfully (pulse) |
| err_o | output | 1 | Sequence failed (pulse) |
| wedged_o | output | 1 | Terminal failed state |

## Verification
The bench builds the block with four engines at distinct base addresses and a TIMEOUT_CYC of 40 instead of the millisecond-scale default. This lets both timeout paths, the per-engine poll budget and the completion wait, expire in a few dozen cycles. It also lets an engine that answers after 30 cycles probe the near-limit success case. The four-engine setup places a stuck engine in the middle of the order, which exposes whether rollback covers engines that were never requested.

// File: rtl/ers_pkg.sv
package ers_pkg;
    localparam logic [31:0] CTL_OFS  = 32'h0000_00D0;
    localparam int          REQ_BIT  = 0;
    localparam int          RDY_BIT  = 1;
    localparam int          MASK_SH  = 16;

    typedef enum logic [2:0] {
        S_IDLE, S_SET, S_POLL, S_CLR, S_RWAIT, S_WEDGE
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_RD, OP_SET, OP_CLR
    } bus_op_t;
endpackage

// File: rtl/ers_timer.sv
module ers_timer #(
    parameter int LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic exp_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (cnt_q != LIM)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign exp_o = (cnt_q == LIM);
endmodule

// File: rtl/ers_bus_enc.sv
module ers_bus_enc
    import ers_pkg::*;
#(
    parameter int N_ENG  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2,
    parameter logic [N_ENG*ADDR_W-1:0] ENG_BASE = '0
) (
    input  bus_op_t           op_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              wr_o
);
    logic [ADDR_W-1:0] ctl_addr [N_ENG];

    for (genvar g = 0; g < N_ENG; g++) begin : g_addr
        assign ctl_addr[g] = ENG_BASE[g*ADDR_W +: ADDR_W] + ADDR_W'(CTL_OFS);
    end

    localparam logic [DATA_W-1:0] EN_REQ  = DATA_W'(1) << (MASK_SH + REQ_BIT);
    localparam logic [DATA_W-1:0] VAL_REQ = DATA_W'(1) << REQ_BIT;

    always_comb begin
        addr_o = '0;
        for (int i = 0; i < N_ENG; i++)
            if (idx_i == IDX_W'(i)) addr_o = ctl_addr[i];
        unique case (op_i)
            OP_SET:  begin wdata_o = EN_REQ | VAL_REQ; wr_o = 1'b1; end
            OP_CLR:  begin wdata_o = EN_REQ;           wr_o = 1'b1; end
            default: begin wdata_o = '0;               wr_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/eng_rst_seq.sv
module eng_rst_seq
    import ers_pkg::*;
#(
    parameter int N_ENG       = 4,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int TIMEOUT_CYC = 70_000_000,
    parameter logic [N_ENG*ADDR_W-1:0] ENG_BASE =
        {32'h0001_C000, 32'h0001_A000, 32'h0001_2000, 32'h0000_2000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              unwedge_i,
    output logic              bus_vld_o,
    output logic              bus_wr_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              grst_o,
    input  logic              grst_done_i,
    output logic              done_o,
    output logic              err_o,
    output logic              wedged_o
);
    localparam int IDX_W = (N_ENG > 1) ? $clog2(N_ENG) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENG - 1);

    typedef struct packed {
        seq_state_t       st;
        logic [IDX_W-1:0] idx;
        logic             grst;
        logic             done;
        logic             err;
    } seq_t;

    seq_t    seq_d, seq_q;
    bus_op_t op;
    logic    tmr_clr, tmr_exp;

    ers_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .exp_o (tmr_exp)
    );

    ers_bus_enc #(
        .N_ENG(N_ENG), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .IDX_W(IDX_W), .ENG_BASE(ENG_BASE)
    ) u_enc (
        .op_i    (op),
        .idx_i   (seq_q.idx),
        .addr_o  (bus_addr_o),
        .wdata_o (bus_wdata_o),
        .wr_o    (bus_wr_o)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.grst = 1'b0;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        op         = OP_RD;
        bus_vld_o  = 1'b0;
        tmr_clr    = 1'b1;
        unique case (seq_q.st)
            S_IDLE: begin
                if (start_i) begin
                    seq_d.st  = S_SET;
                    seq_d.idx = '0;
                end
            end
            S_SET: begin
                bus_vld_o = 1'b1;
                op        = OP_SET;
                if (bus_ack_i) seq_d.st = S_POLL;
            end
            S_POLL: begin
                bus_vld_o = 1'b1;
                tmr_clr   = 1'b0;
                if (bus_ack_i) begin
                    if (bus_rdata_i[RDY_BIT]) begin
                        tmr_clr = 1'b1;
                        if (seq_q.idx == LAST) begin
                            seq_d.st   = S_RWAIT;
                            seq_d.grst = 1'b1;
                        end else begin
                            seq_d.st  = S_SET;
                            seq_d.idx = seq_q.idx + 1'b1;
                        end
                    end else if (tmr_exp) begin
                        seq_d.st  = S_CLR;
                        seq_d.idx = '0;
                    end
                end
            end
            S_CLR: begin
                bus_vld_o = 1'b1;
                op        = OP_CLR;
                if (bus_ack_i) begin
                    if (seq_q.idx == LAST) begin
                        seq_d.st  = S_WEDGE;
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            S_RWAIT: begin
                tmr_clr = 1'b0;
                if (grst_done_i) begin
                    seq_d.st   = S_IDLE;
                    seq_d.done = 1'b1;
                end else if (tmr_exp) begin
                    seq_d.st  = S_WEDGE;
                    seq_d.err = 1'b1;
                end
            end
            S_WEDGE: begin
                if (unwedge_i) seq_d.st = S_IDLE;
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: S_IDLE, idx: '0, grst: 1'b0, done: 1'b0, err: 1'b0};
        else        seq_q <= seq_d;
    end

    assign grst_o   = seq_q.grst;
    assign done_o   = seq_q.done;
    assign err_o    = seq_q.err;
    assign wedged_o = (seq_q.st == S_WEDGE);
endmodule

// File: rtl/eng_rst_seq_chk.sv
module eng_rst_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              unwedge_i,
    input logic              bus_vld_o,
    input logic              bus_wr_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [DATA_W-1:0] bus_wdata_o,
    input logic              bus_ack_i,
    input logic              grst_o,
    input logic              grst_done_i,
    input logic              done_o,
    input logic              err_o,
    input logic              wedged_o
);
    assert_grst_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grst_o |=> !grst_o);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld_o && !bus_ack_i) |=> (bus_vld_o && $stable(bus_addr_o)
                                       && $stable(bus_wdata_o) && $stable(bus_wr_o)));

    assert_one_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grst_o, done_o, err_o}));

    assert_err_wedges_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> wedged_o);

    assert_wedge_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wedged_o && !unwedge_i) |=> wedged_o);

    assert_wedge_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wedged_o |-> !bus_vld_o && !grst_o);

    assert_no_done_wedged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wedged_o);
endmodule

bind eng_rst_seq eng_rst_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/eng_rst_seq_bench.sv
module eng_rst_seq_bench;
    localparam int N  = 4;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int TO = 40;
    localparam logic [N*AW-1:0] BASES =
        {32'h0004_0000, 32'h0003_0000, 32'h0002_0000, 32'h0001_0000};
    localparam int EV_WR = 0, EV_GRST = 1, EV_DONE = 2, EV_ERR = 3;

    typedef struct { int kind; logic [31:0] addr; logic [31:0] data; string req; } exp_t;

    logic clk = 0, rst_n = 0, start = 0, unwedge = 0;
    logic bus_vld, bus_wr, bus_ack = 0, grst, gdone = 0, done, err, wedged;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;

    int checks = 0, failures = 0;
    exp_t exp_q[$];
    logic [31:0] last_wr_addr = '0;
    bit grst_resp = 1;
    logic eng_req [N];
    int   eng_cnt [N];
    int   eng_dly [N];

    always #10 clk = ~clk;

    eng_rst_seq #(.N_ENG(N), .ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYC(TO), .ENG_BASE(BASES)) u_eng_rst_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .unwedge_i(unwedge),
        .bus_vld_o(bus_vld), .bus_wr_o(bus_wr), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
        .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata), .grst_o(grst), .grst_done_i(gdone),
        .done_o(done), .err_o(err), .wedged_o(wedged));

    function automatic logic [31:0] ctl(int e);
        return BASES[e*AW +: AW] + 32'hD0;
    endfunction

    // engine register model: bit0 request, bit1 ready; upper half masks lower half
    always_comb begin
        bus_rdata = '0;
        for (int e = 0; e < N; e++)
            if (bus_addr == ctl(e))
                bus_rdata = {30'b0, eng_req[e] && (eng_cnt[e] >= eng_dly[e]), eng_req[e]};
    end

    always @(posedge clk) begin
        bus_ack <= bus_vld && !bus_ack;
        gdone   <= grst_resp && grst;
        for (int e = 0; e < N; e++) begin
            if (eng_req[e]) eng_cnt[e] <= eng_cnt[e] + 1;
            if (bus_vld && bus_ack && bus_wr && bus_addr == ctl(e) && bus_wdata[16]) begin
                eng_req[e] <= bus_wdata[0];
                eng_cnt[e] <= 0;
            end
            if (grst) eng_req[e] <= 1'b0;
        end
    end

    function automatic void check_ev(int kind, logic [31:0] a, logic [31:0] d);
        exp_t x;
        checks++;
        if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL unexpected event kind=%0d addr=%h data=%h (expected none)", kind, a, d);
            return;
        end
        x = exp_q.pop_front();
        if (x.kind != kind || (kind == EV_WR && (x.addr != a || x.data != d))) begin
            failures++;
            $display("FAIL %s: got kind=%0d addr=%h data=%h expected kind=%0d addr=%h data=%h",
                     x.req, kind, a, d, x.kind, x.addr, x.data);
        end
    endfunction

    // monitor
    always @(negedge clk) if (rst_n) begin
        if (bus_vld && bus_ack && bus_wr) begin
            check_ev(EV_WR, bus_addr, bus_wdata);
            last_wr_addr = bus_addr;
        end
        if (bus_vld && bus_ack && !bus_wr) begin
            checks++;
            if (bus_addr != last_wr_addr) begin
                failures++;
                $display("FAIL R2 poll address got=%h expected=%h", bus_addr, last_wr_addr);
            end
        end
        if (grst) check_ev(EV_GRST, 0, 0);
        if (done) check_ev(EV_DONE, 0, 0);
        if (err)  check_ev(EV_ERR, 0, 0);
    end

    task automatic push(int kind, logic [31:0] a, logic [31:0] d, string r);
        exp_t x;
        x.kind = kind; x.addr = a; x.data = d; x.req = r;
        exp_q.push_back(x);
    endtask

    task automatic check_bit(string r, logic got, logic want);
        checks++;
        if (got !== want) begin
            failures++;
            $display("FAIL %s got=%b expected=%b", r, got, want);
        end
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1; @(negedge clk); s = 0;
    endtask

    task automatic wait_drain(string r);
        int c = 0;
        while (exp_q.size() != 0 && c < 3000) begin @(negedge clk); c++; end
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL %s pending=%0d expected=0", r, exp_q.size());
            exp_q.delete();
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic quiet(string r, int n);
        int act = 0;
        repeat (n) begin @(negedge clk); if (bus_vld || grst) act++; end
        checks++;
        if (act != 0) begin
            failures++;
            $display("FAIL %s bus/reset activity=%0d expected=0", r, act);
        end
    endtask

    // good run: set requests in order, then reset pulse and done
    task automatic exp_good(string r);
        for (int e = 0; e < N; e++) push(EV_WR, ctl(e), 32'h0001_0001, "R2");
        push(EV_GRST, 0, 0, "R3");
        push(EV_DONE, 0, 0, r);
    endtask

    task automatic exp_abort(int upto);
        for (int e = 0; e <= upto; e++) push(EV_WR, ctl(e), 32'h0001_0001, "R2");
        for (int e = 0; e < N; e++) push(EV_WR, ctl(e), 32'h0001_0000, "R5");
        push(EV_ERR, 0, 0, "R5");
    endtask

    initial begin
        for (int e = 0; e < N; e++) begin eng_req[e] = 0; eng_cnt[e] = 0; eng_dly[e] = 0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        check_bit("R1 vld", bus_vld, 0); check_bit("R1 grst", grst, 0);
        check_bit("R1 done", done, 0); check_bit("R1 err", err, 0); check_bit("R1 wedged", wedged, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2 R3 R4 R7: varied ready delays, extra start mid-run
        eng_dly = '{0, 3, 7, 1};
        exp_good("R4");
        pulse(start);
        repeat (5) @(negedge clk);
        pulse(start);   // R7: ignored while busy
        wait_drain("R4");
        quiet("R7 no second run", 30);
        check_bit("R4 not wedged", wedged, 0);

        // R9: engine 1 answers late but inside the budget
        eng_dly = '{2, 30, 0, 28};
        exp_good("R9");
        pulse(start);
        wait_drain("R9");

        // R5: engine 2 never ready
        eng_dly = '{0, 2, 1000000, 0};
        exp_abort(2);
        pulse(start);
        wait_drain("R5");
        check_bit("R6 wedged", wedged, 1);
        for (int e = 0; e < N; e++) check_bit("R5 request withdrawn", eng_req[e], 0);

        // R6: start ignored while wedged, then unwedge
        pulse(start);
        quiet("R6 start while wedged", 40);
        check_bit("R6 still wedged", wedged, 1);
        pulse(unwedge);
        @(negedge clk);
        check_bit("R6 unwedged", wedged, 0);
        eng_dly = '{4, 0, 2, 5};
        exp_good("R6 run after unwedge");
        pulse(start);
        wait_drain("R6");

        // R5: first engine stuck
        eng_dly = '{1000000, 0, 0, 0};
        exp_abort(0);
        pulse(start);
        wait_drain("R5 first engine");
        pulse(unwedge);
        repeat (2) @(negedge clk);

        // R8: completion acknowledge never arrives
        grst_resp = 0;
        eng_dly = '{0, 0, 0, 0};
        for (int e = 0; e < N; e++) push(EV_WR, ctl(e), 32'h0001_0001, "R2");
        push(EV_GRST, 0, 0, "R3");
        push(EV_ERR, 0, 0, "R8");
        pulse(start);
        wait_drain("R8");
        check_bit("R8 wedged", wedged, 1);
        check_bit("R8 no done", done, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule